// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM that has 32768 eight-bit words. The host hands it one word at a time over a valid/ready request carrying a 15-bit address, a write flag and write data. For each request the block produces the chip-enable, write-enable and output-enable strobes (all active low), holds the address and write data steady, and says when the pad drivers for the data bus may drive. Read data returns with a one-cycle valid pulse.

All timing comes from nanosecond limits given as parameters. Each limit is turned into clock cycles by rounding up, with at least one cycle per phase. A write keeps output enable high and ends when write enable rises while chip enable stays low. A read is followed by a gap of idle cycles, so the block never starts driving the bus while the RAM may still be driving it.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `req_ready` is 1, `ram_ce_n`, `ram_we_n` and `ram_oe_n` are 1, and `ram_dq_oe` and `rsp_valid` are 0.
- R2: An accepted read (`req_write`=0) holds `ram_ce_n`=0, `ram_oe_n`=0 and `ram_we_n`=1 for RD+1 cycles, where RD is the access time in cycles. `ram_dq_oe` stays 0 and `ram_addr` equals the request address throughout.
- R3: Read data is registered at the end of the last strobe cycle. `rsp_valid` is a single-cycle pulse in the (RD+2)-th cycle after acceptance, and `rsp_rdata` then holds the word stored at that address.
- R4: An accepted write (`req_write`=1) gives one setup cycle (`ram_ce_n`=0, `ram_we_n`=1), then WP cycles with `ram_we_n`=0, then one release cycle (`ram_ce_n`=0, `ram_we_n`=1). `ram_oe_n` stays 1 in all three phases.
- R5: `ram_dq_oe` is 1 exactly in the three write phases, and `ram_dq_out` carries the request's write data there. It is still 1 on the edge where `ram_we_n` rises (zero hold), and it is never 1 while `ram_oe_n` is 0.
- R6: `ram_addr` changes only on the cycle a request is accepted. It never changes while `ram_we_n` is 0.
- R7: After a read, all strobes are high and `ram_dq_oe` is 0 for TA cycles, where TA is the output-float time in cycles. Only after that can another request be accepted, so bus drive starts at least TA cycles after `ram_oe_n` rises.
- R8: `req_ready` is 1 only in idle. It is low from acceptance for RD+1+TA cycles (read) or 1+WP+1 cycles (write). A `req_valid` pulse while `req_ready` is 0 is ignored.
- R9: Cycle counts equal ceil(ns*1000/CLK_PS), with a minimum of 1. RD comes from the access time and TA from the output-float time. WP is the largest of the write-pulse count, the data-setup count, and the write-cycle count minus 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Read data |
| ram_addr | output | 15 | Address to the RAM |
| ram_ce_n | output | 1 | Chip enable, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_dq_out | output | 8 | Data toward the RAM pads |
| ram_dq_oe | output | 1 | Pad driver enable for ram_dq_out |
| ram_dq_in | input | 8 | Data from the RAM pads |

## Verification
Two events can fall in the same cycle. The first is the end of a read's output-float gap, when ready returns. The second is acceptance of a write, which starts bus drive on the next edge. The bench provokes this by presenting the next request on the very cycle ready rises, through a long mix of random reads and writes and directed read-then-write pairs. A behavioural RAM model in the bench keeps its outputs alive for the float time after output enable rises and holds read data invalid until the access time has passed. Any overlap of controller drive with that window counts as a miscompare, and so does a read that samples too early.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_CAP,
    ST_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_REL
  } ctl_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 5,
  parameter int WS_CYC  = 1,
  parameter int WP_CYC  = 3,
  parameter int REL_CYC = 1,
  parameter int TA_CYC  = 3,
  parameter int CW      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_wr,
  output ctl_state_e state,
  output logic       capture_evt
);

  ctl_state_e      nxt;
  logic [CW-1:0]   cnt;
  logic            phase_last;

  function automatic logic [CW-1:0] span(input ctl_state_e s);
    case (s)
      ST_RD_ACC:   return CW'(RD_CYC - 1);
      ST_TURN:     return CW'(TA_CYC - 1);
      ST_WR_SETUP: return CW'(WS_CYC - 1);
      ST_WR_PULSE: return CW'(WP_CYC - 1);
      ST_WR_REL:   return CW'(REL_CYC - 1);
      default:     return '0;
    endcase
  endfunction

  assign phase_last  = (cnt == '0);
  assign capture_evt = (state == ST_RD_CAP);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:     if (start) nxt = start_wr ? ST_WR_SETUP : ST_RD_ACC;
      ST_RD_ACC:   if (phase_last) nxt = ST_RD_CAP;
      ST_RD_CAP:   nxt = ST_TURN;
      ST_TURN:     if (phase_last) nxt = ST_IDLE;
      ST_WR_SETUP: if (phase_last) nxt = ST_WR_PULSE;
      ST_WR_PULSE: if (phase_last) nxt = ST_WR_REL;
      ST_WR_REL:   if (phase_last) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state)     cnt <= span(nxt);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
  end

  // R7
  turn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TURN && !phase_last) |=> (state == ST_TURN));

  // R4
  pulse_follows_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_WR_PULSE) |-> $past(state == ST_WR_SETUP));

endmodule

// File: rtl/sram_strobe_dec.sv
module sram_strobe_dec
  import sram_ctrl_pkg::*;
(
  input  ctl_state_e state,
  output logic       ce_n,
  output logic       we_n,
  output logic       oe_n,
  output logic       dq_oe
);

  always_comb begin
    ce_n  = 1'b1;
    we_n  = 1'b1;
    oe_n  = 1'b1;
    dq_oe = 1'b0;
    case (state)
      ST_RD_ACC, ST_RD_CAP: begin
        ce_n = 1'b0;
        oe_n = 1'b0;
      end
      ST_WR_SETUP, ST_WR_REL: begin
        ce_n  = 1'b0;
        dq_oe = 1'b1;
      end
      ST_WR_PULSE: begin
        ce_n  = 1'b0;
        we_n  = 1'b0;
        dq_oe = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sram_dpath.sv
module sram_dpath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture_evt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ram_dq_in,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_addr   <= '0;
      ram_dq_out <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (accept) begin
        ram_addr   <= req_addr;
        ram_dq_out <= req_wdata;
      end
      rsp_valid <= capture_evt;
      if (capture_evt) rsp_rdata <= ram_dq_in;
    end
  end

  // R3
  rsp_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> rsp_valid);

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PS   = 8000,
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int T_ACC_NS = 35,
  parameter int T_AS_NS  = 0,
  parameter int T_WP_NS  = 20,
  parameter int T_DS_NS  = 15,
  parameter int T_WC_NS  = 35,
  parameter int T_WR_NS  = 0,
  parameter int T_OHZ_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);

  localparam int RD_CYC  = ns_to_cyc(T_ACC_NS, CLK_PS);
  localparam int WS_CYC  = ns_to_cyc(T_AS_NS, CLK_PS);
  localparam int REL_CYC = ns_to_cyc(T_WR_NS, CLK_PS);
  localparam int WP_CYC  = max_of(max_of(ns_to_cyc(T_WP_NS, CLK_PS),
                                         ns_to_cyc(T_DS_NS, CLK_PS)),
                                  ns_to_cyc(T_WC_NS, CLK_PS) - WS_CYC - REL_CYC);
  localparam int TA_CYC  = ns_to_cyc(T_OHZ_NS, CLK_PS);
  localparam int MAXLEN  = max_of(max_of(RD_CYC, WP_CYC), max_of(TA_CYC, max_of(WS_CYC, REL_CYC)));
  localparam int CW      = $clog2(MAXLEN + 1);

  ctl_state_e state;
  logic       accept;
  logic       capture_evt;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  sram_phase_seq #(
    .RD_CYC(RD_CYC), .WS_CYC(WS_CYC), .WP_CYC(WP_CYC),
    .REL_CYC(REL_CYC), .TA_CYC(TA_CYC), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_wr(req_write),
    .state(state), .capture_evt(capture_evt)
  );

  sram_strobe_dec u_dec (
    .state(state), .ce_n(ram_ce_n), .we_n(ram_we_n),
    .oe_n(ram_oe_n), .dq_oe(ram_dq_oe)
  );

  sram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture_evt(capture_evt),
    .req_addr(req_addr), .req_wdata(req_wdata), .ram_dq_in(ram_dq_in),
    .ram_addr(ram_addr), .ram_dq_out(ram_dq_out),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // Observation counters for the timing assertions
  logic [CW-1:0] we_low_cnt;
  logic [CW-1:0] oe_high_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_low_cnt  <= '0;
      oe_high_cnt <= CW'(TA_CYC);
    end else begin
      if (!ram_we_n)              we_low_cnt <= we_low_cnt + 1'b1;
      else                        we_low_cnt <= '0;
      if (!ram_oe_n)              oe_high_cnt <= '0;
      else if (oe_high_cnt < CW'(TA_CYC)) oe_high_cnt <= oe_high_cnt + 1'b1;
    end
  end

  // R4
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_low_cnt >= CW'(WP_CYC)));

  // R5
  no_drive_when_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (ram_oe_n && !ram_ce_n));

  // R6
  addr_still_under_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |=> (ram_we_n || $stable(ram_addr)));

  // R7
  turnaround_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_dq_oe) |-> (oe_high_cnt >= CW'(TA_CYC)));

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R3
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/tb_sram_bus_ctrl.sv
`timescale 1ns/1ps
module tb_sram_bus_ctrl;

  localparam int B_CLK_PS = 8000;

  // R9: independent restatement of the cycle rounding
  function automatic int bcyc(input int ns);
    int n;
    n = 1;
    while (n * B_CLK_PS < ns * 1000) n++;
    return n;
  endfunction

  localparam int RD_B  = bcyc(35);
  localparam int WS_B  = bcyc(0);
  localparam int REL_B = bcyc(0);
  localparam int WPA_B = (bcyc(20) > bcyc(15)) ? bcyc(20) : bcyc(15);
  localparam int WP_B  = (WPA_B > bcyc(35) - 2) ? WPA_B : bcyc(35) - 2;
  localparam int TA_B  = bcyc(20);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [7:0]  rsp_rdata, ram_dq_out, ram_dq_in;
  logic [14:0] ram_addr;

  always #4 clk = ~clk;

  sram_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural RAM model ----------------
  logic [7:0] ram_mem [logic [14:0]];
  logic [7:0] ref_mem [logic [14:0]];

  function automatic logic [7:0] bg(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ram_look(input logic [14:0] a);
    if (ram_mem.exists(a)) return ram_mem[a];
    return bg(a);
  endfunction

  function automatic logic [7:0] ref_look(input logic [14:0] a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return bg(a);
  endfunction

  logic ram_drv;
  int   rd_age = 0;
  int   float_age = 100;
  logic [7:0] rd_word = '0;
  logic wr_pend = 1'b0;
  logic [7:0] wr_dat = '0;
  logic [14:0] wr_adr = '0;
  int   wr_len = 0;
  logic prev_we_low = 1'b0;
  logic [14:0] prev_addr = '0;

  assign ram_drv   = !ram_ce_n && ram_we_n && !ram_oe_n;
  assign ram_dq_in = (ram_drv && rd_age >= RD_B) ? rd_word : 8'hEE;

  always @(posedge clk) begin
    if (rst_n) begin
      rd_word <= ram_look(ram_addr);
      if (ram_drv) begin
        rd_age    <= rd_age + 1;
        float_age <= 0;
      end else begin
        rd_age <= 0;
        if (float_age < 100) float_age <= float_age + 1;
      end
      // R7: controller drive while the RAM may still be driving
      if (ram_dq_oe)
        check(!ram_drv && float_age >= TA_B, "R7", "bus overlap age",
              float_age, TA_B);
      if (!ram_ce_n && !ram_we_n) begin
        wr_pend <= 1'b1;
        wr_dat  <= ram_dq_out;
        wr_adr  <= ram_addr;
        wr_len  <= wr_len + 1;
      end else if (wr_pend) begin
        ram_mem[wr_adr] = wr_dat;
        wr_pend <= 1'b0;
        wr_len  <= 0;
        check(wr_len >= WP_B, "R4/R9", "write pulse cycles", wr_len, WP_B);
        // R5: data still driven at the write-ending edge
        check(ram_dq_oe && ram_dq_out == wr_dat, "R5", "hold at we rise",
              int'(ram_dq_out), int'(wr_dat));
      end
      if (!ram_we_n && prev_we_low && ram_addr != prev_addr)
        check(1'b0, "R6", "addr moved under we", int'(ram_addr), int'(prev_addr));
      prev_we_low <= !ram_we_n;
      prev_addr   <= ram_addr;
    end
  end

  // ---------------- host tasks ----------------
  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d, input bit intrude);
    int i;
    int bad;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    i = 0; bad = 0;
    while (!req_ready && i < 50) begin
      i++;
      if (intrude && i == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 15'h0001; req_wdata = ~d;
      end else if (intrude && i == 3) begin
        req_valid = 1'b0;
      end
      if (ram_ce_n || !ram_oe_n || !ram_dq_oe || ram_dq_out != d || ram_addr != a) bad++;
      if (ram_we_n != !(i > WS_B && i <= WS_B + WP_B)) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R4", "write strobe shape errors", bad, 0);
    check(i == WS_B + WP_B + REL_B, "R8", "write busy cycles", i, WS_B + WP_B + REL_B);
    ref_mem[a] = d;
  endtask

  task automatic do_read(input logic [14:0] a);
    int i;
    int bad_rd;
    int bad_ta;
    int lat;
    logic [7:0] got;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    i = 0; bad_rd = 0; bad_ta = 0; lat = -1; got = '0;
    while (!req_ready && i < 50) begin
      i++;
      if (i <= RD_B + 1) begin
        if (ram_ce_n || ram_oe_n || !ram_we_n || ram_dq_oe || ram_addr != a) bad_rd++;
      end else begin
        if (!ram_ce_n || !ram_oe_n || !ram_we_n || ram_dq_oe) bad_ta++;
      end
      if (rsp_valid) begin
        if (lat < 0) begin lat = i; got = rsp_rdata; end
        else lat = 99;
      end
      @(negedge clk);
    end
    check(bad_rd == 0, "R2", "read strobe shape errors", bad_rd, 0);
    check(bad_ta == 0, "R7", "turnaround strobe errors", bad_ta, 0);
    check(lat == RD_B + 2, "R3", "rsp_valid cycle", lat, RD_B + 2);
    check(got == ref_look(a), "R3", "read data", int'(got), int'(ref_look(a)));
    check(i == RD_B + 1 + TA_B, "R8", "read busy cycles", i, RD_B + 1 + TA_B);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1 during reset
    check(req_ready && ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe && !rsp_valid,
          "R1", "reset outputs", {req_ready, ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid},
          6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe && !rsp_valid,
          "R1", "idle outputs", {req_ready, ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid},
          6'b111100);

    // directed corners
    do_read(15'h0000);
    do_write(15'h0000, 8'hC3, 1'b0);
    do_read(15'h0000);
    do_write(15'h7FFF, 8'h3C, 1'b0);
    do_write(15'h7FFE, 8'hA1, 1'b0);
    do_read(15'h7FFF);
    do_read(15'h7FFE);
    // R8: request pulsed while busy must not land
    do_write(15'h0100, 8'h11, 1'b1);
    do_read(15'h0101);
    do_read(15'h0100);

    // constrained random mix, addresses concentrated on a small window
    for (int k = 0; k < 300; k++) begin
      logic [14:0] a;
      if ($urandom % 4 == 0) a = 15'($urandom);
      else a = {13'($urandom % 2) << 13} | 15'($urandom % 16);
      if ($urandom % 2 == 0) do_write(a, 8'($urandom), 1'b0);
      else do_read(a);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule